// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block holds the receive and transmit byte queues of a 16550-style serial port, together with the control that a host programs through a single FIFO control byte. The deserializer pushes received bytes and the host reads them. The host writes bytes for transmission and the serializer pops them. The control byte turns queueing on or off, empties either queue on command, records a DMA mode flag and picks the receive trigger level. The block reports data-ready, holding-empty, transmitter-empty, the level of each queue, the decoded trigger level and a sticky overrun flag.

A character-timeout timer covers the case where bytes sit below the trigger level. Each accepted receive byte, and each host read that leaves bytes behind, restarts the timer at four character times. The character time is an input, counted in clock cycles. If the timer expires while the receive queue still holds data, a timeout flag is raised. A host read clears that flag. With queueing disabled, each direction holds one byte. Interrupt encoding and the bit-level shifters live elsewhere.

Top module: `uart_fifo_ctl`

## Requirements
- R1: A control write stores bit 0 as the queue enable (`fifo_en`), bit 3 as `dma_mode` and bits 7:6 as the trigger code. Bits 1, 2, 4 and 5 are not retained. Reset clears all stored fields.
- R2: The trigger codes 00, 01, 10 and 11 give a `trig_level` of 1, 4, 8 and 14 bytes.
- R3: A control write whose bit 0 differs from the current enable empties both queues in that cycle, whatever bits 1 and 2 hold.
- R4: A control write with bit 1 set empties the receive queue. It also clears the timeout flag, stops the timer and clears overrun. A write with bit 2 set empties the transmit queue. Neither bit is retained.
- R5: Bytes leave each queue in arrival order. The capacity is DEPTH (16) with queueing enabled and 1 with it disabled. `rd_data` shows the oldest byte, or 0 when the queue is empty, and a read of an empty queue changes nothing.
- R6: A receive push into a full queue, with no read in the same cycle, drops the byte and sets `overrun`. Overrun stays set until a receive flush or reset.
- R7: With queueing enabled, the timer restarts on each accepted receive push, and on each read that leaves bytes in the queue. `timeout_pend` rises exactly 4×`char_time` cycles after the last restart, and only if the receive queue was non-empty at expiry.
- R8: A host read (`rd_en`) clears `timeout_pend` in the next cycle, even when the queue is empty.
- R9: `data_ready` is high exactly when the receive queue holds at least one byte.
- R10: `thr_empty` is high exactly when the transmit queue is empty. A holding write into a full transmit queue, with no pop in the same cycle, is dropped.
- R11: Any holding write clears `tx_empty` in the next cycle. `tx_empty` sets again one cycle after a cycle in which the transmit queue is empty and `ser_idle` is high. Reset sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcr_we | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte value |
| char_time | input | CT_W | One character time in clock cycles |
| rx_push | input | 1 | Deserializer delivers a byte |
| rx_byte | input | DATA_W | Received byte |
| rd_en | input | 1 | Host reads the receive buffer |
| rd_data | output | DATA_W | Oldest received byte, 0 when empty |
| thr_we | input | 1 | Host writes the holding register |
| thr_wdata | input | DATA_W | Byte to transmit |
| tx_pop | input | 1 | Serializer takes a byte |
| ser_idle | input | 1 | Serializer shift stage is empty |
| tx_data | output | DATA_W | Oldest transmit byte, 0 when empty |
| tx_avail | output | 1 | Transmit queue non-empty |
| rx_level | output | CW | Receive queue occupancy |
| tx_level | output | CW | Transmit queue occupancy |
| data_ready | output | 1 | Receive data present |
| thr_empty | output | 1 | Transmit queue empty |
| tx_empty | output | 1 | Transmitter fully empty |
| fifo_en | output | 1 | Queueing enabled |
| dma_mode | output | 1 | Stored DMA mode flag |
| trig_level | output | 5 | Receive trigger level in bytes |
| timeout_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | Receive byte dropped on full queue |

## Verification
Random pushes, reads, writes and pops run against a bench model of both queues and the timer. Control writes are rare, so the queues run for long stretches between flushes, and the timeouts that occur tell exact expiry counting apart from off-by-one timers. Directed sequences cover the following cases:
- Filling to 17 bytes, which separates drop-on-full from overwrite.
- Toggling the enable with the flush bits clear, which exposes a missing forced flush.
- A receive-only flush, which shows that the transmit side is left untouched.
- Single-byte mode, which shows the capacity switching with the enable.
- Each trigger code, which checks the level decode.

// File: rtl/ufc_pkg.sv
package ufc_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int BYTE_W     = 8;
    localparam int CHAR_T_W   = 16;
    localparam int TRIG_W     = 5;

    typedef enum logic [1:0] {
        TRIG_ONE      = 2'b00,
        TRIG_FOUR     = 2'b01,
        TRIG_EIGHT    = 2'b10,
        TRIG_FOURTEEN = 2'b11
    } trig_code_e;

    // Fields of the control byte that survive a write
    typedef struct packed {
        trig_code_e trig;
        logic       dma;
        logic       en;
    } fcr_keep_t;

    function automatic logic [TRIG_W-1:0] trig_bytes(trig_code_e c);
        case (c)
            TRIG_ONE:   return TRIG_W'(1);
            TRIG_FOUR:  return TRIG_W'(4);
            TRIG_EIGHT: return TRIG_W'(8);
            default:    return TRIG_W'(14);
        endcase
    endfunction

    function automatic fcr_keep_t fcr_capture(logic [7:0] w);
        fcr_keep_t f;
        f.trig = trig_code_e'(w[7:6]);
        f.dma  = w[3];
        f.en   = w[0];
        return f;
    endfunction

endpackage

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
    parameter  int DEPTH = 16,
    parameter  int W     = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    input  logic [CW-1:0] cap,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          push_ok,
    output logic          pop_ok,
    output logic          drop
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // A pop in the same cycle frees the slot a full-queue push needs
    assign pop_ok  = pop && (count != '0);
    assign push_ok = push && ((count < cap) || pop_ok);
    assign drop    = push && !push_ok;
    assign dout    = (count != '0) ? mem[rd_ptr] : '0;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && push_ok) mem[wr_ptr] <= din;
    end

endmodule

// File: rtl/ufc_char_timer.sv
module ufc_char_timer #(
    parameter  int CT_W = 16,
    localparam int LW   = CT_W + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            restart,
    input  logic [CT_W-1:0] char_time,
    input  logic            data_present,
    input  logic            rd_clear,
    output logic            pend
);

    logic [LW-1:0] cnt;
    logic          armed;
    logic          expire;

    assign expire = armed && (cnt <= LW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            armed <= 1'b0;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            if (restart) begin
                armed <= 1'b1;
                cnt   <= {char_time, 2'b00};
            end else if (armed) begin
                if (expire) armed <= 1'b0;
                else        cnt   <= cnt - LW'(1);
            end
            if (rd_clear)                    pend <= 1'b0;
            else if (expire && data_present) pend <= 1'b1;
        end
    end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
    parameter  int DEPTH  = ufc_pkg::FIFO_DEPTH,
    parameter  int DATA_W = ufc_pkg::BYTE_W,
    parameter  int CT_W   = ufc_pkg::CHAR_T_W,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      fcr_we,
    input  logic [7:0]                fcr_wdata,
    input  logic [CT_W-1:0]           char_time,
    input  logic                      rx_push,
    input  logic [DATA_W-1:0]         rx_byte,
    input  logic                      rd_en,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      thr_we,
    input  logic [DATA_W-1:0]         thr_wdata,
    input  logic                      tx_pop,
    input  logic                      ser_idle,
    output logic [DATA_W-1:0]         tx_data,
    output logic                      tx_avail,
    output logic [CW-1:0]             rx_level,
    output logic [CW-1:0]             tx_level,
    output logic                      data_ready,
    output logic                      thr_empty,
    output logic                      tx_empty,
    output logic                      fifo_en,
    output logic                      dma_mode,
    output logic [ufc_pkg::TRIG_W-1:0] trig_level,
    output logic                      timeout_pend,
    output logic                      overrun
);
    import ufc_pkg::*;

    fcr_keep_t fcr_q;
    logic      en_flip, flush_rx, flush_tx;
    logic [CW-1:0] cap;
    logic      rx_push_ok, rx_pop_ok, rx_drop;
    logic      tx_push_ok, tx_pop_ok, tx_drop;
    logic      ovr_q, txe_q, tmr_restart;

    assign en_flip  = fcr_we && (fcr_wdata[0] != fcr_q.en);
    assign flush_rx = fcr_we && (fcr_wdata[1] || en_flip);
    assign flush_tx = fcr_we && (fcr_wdata[2] || en_flip);
    assign cap      = fcr_q.en ? CW'(DEPTH) : CW'(1);

    always_ff @(posedge clk) begin
        if (rst)         fcr_q <= '0;
        else if (fcr_we) fcr_q <= fcr_capture(fcr_wdata);
    end

    ufc_byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush_rx),
        .push(rx_push), .din(rx_byte), .pop(rd_en), .cap(cap),
        .dout(rd_data), .count(rx_level),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok), .drop(rx_drop)
    );

    ufc_byte_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_txq (
        .clk(clk), .rst(rst), .flush(flush_tx),
        .push(thr_we), .din(thr_wdata), .pop(tx_pop), .cap(cap),
        .dout(tx_data), .count(tx_level),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok), .drop(tx_drop)
    );

    // Restart on new data, or on a read that leaves bytes behind
    assign tmr_restart = fcr_q.en &&
                         (rx_push_ok || (rx_pop_ok && rx_level > CW'(1)));

    ufc_char_timer #(.CT_W(CT_W)) u_tmr (
        .clk(clk), .rst(rst), .clear(flush_rx), .restart(tmr_restart),
        .char_time(char_time), .data_present(rx_level != '0),
        .rd_clear(rd_en), .pend(timeout_pend)
    );

    always_ff @(posedge clk) begin
        if (rst || flush_rx) ovr_q <= 1'b0;
        else if (rx_drop)    ovr_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)                               txe_q <= 1'b1;
        else if (thr_we)                       txe_q <= 1'b0;
        else if (tx_level == '0 && ser_idle)   txe_q <= 1'b1;
    end

    assign overrun    = ovr_q;
    assign tx_empty   = txe_q;
    assign data_ready = (rx_level != '0);
    assign thr_empty  = (tx_level == '0);
    assign tx_avail   = !thr_empty;
    assign fifo_en    = fcr_q.en;
    assign dma_mode   = fcr_q.dma;
    assign trig_level = trig_bytes(fcr_q.trig);

    logic unused_sig;
    assign unused_sig = ^{fcr_wdata[5:4], tx_push_ok, tx_pop_ok, tx_drop};

endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_push,
    input logic          rd_en,
    input logic          thr_we,
    input logic [CW-1:0] rx_level,
    input logic [CW-1:0] tx_level,
    input logic          fifo_en,
    input logic [4:0]    trig_level,
    input logic          timeout_pend,
    input logic          data_ready,
    input logic          tx_empty,
    input logic          overrun
);

    // R5
    rx_cap_chk: assert property (@(posedge clk) disable iff (rst)
        rx_level <= (fifo_en ? CW'(DEPTH) : CW'(1)));

    // R5
    tx_cap_chk: assert property (@(posedge clk) disable iff (rst)
        tx_level <= (fifo_en ? CW'(DEPTH) : CW'(1)));

    // R2
    trig_legal_chk: assert property (@(posedge clk) disable iff (rst)
        trig_level == 5'd1 || trig_level == 5'd4 ||
        trig_level == 5'd8 || trig_level == 5'd14);

    // R3
    flip_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_en != $past(fifo_en)) |-> (rx_level == '0 && tx_level == '0));

    // R7
    pend_data_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout_pend) |-> data_ready);

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> !timeout_pend);

    // R11
    txe_clear_chk: assert property (@(posedge clk) disable iff (rst)
        thr_we |=> !tx_empty);

    // R6
    ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(rx_push));

endmodule

bind uart_fifo_ctl ufc_checker #(.DEPTH(DEPTH), .CW(CW)) u_ufc_chk (
    .clk(clk), .rst(rst), .rx_push(rx_push), .rd_en(rd_en), .thr_we(thr_we),
    .rx_level(rx_level), .tx_level(tx_level), .fifo_en(fifo_en),
    .trig_level(trig_level), .timeout_pend(timeout_pend),
    .data_ready(data_ready), .tx_empty(tx_empty), .overrun(overrun)
);

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;

    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fcr_we = 0, rx_push = 0, rd_en = 0, thr_we = 0, tx_pop = 0, ser_idle = 0;
    logic [7:0]  fcr_wdata = 0, rx_byte = 0, thr_wdata = 0;
    logic [15:0] char_time = 16'd3;
    logic [7:0]  rd_data, tx_data;
    logic        tx_avail, data_ready, thr_empty, tx_empty, fifo_en, dma_mode;
    logic        timeout_pend, overrun;
    logic [CW-1:0] rx_level, tx_level;
    logic [4:0]  trig_level;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    uart_fifo_ctl u_uart_fifo_ctl (
        .clk(clk), .rst(rst), .fcr_we(fcr_we), .fcr_wdata(fcr_wdata),
        .char_time(char_time), .rx_push(rx_push), .rx_byte(rx_byte),
        .rd_en(rd_en), .rd_data(rd_data), .thr_we(thr_we), .thr_wdata(thr_wdata),
        .tx_pop(tx_pop), .ser_idle(ser_idle), .tx_data(tx_data), .tx_avail(tx_avail),
        .rx_level(rx_level), .tx_level(tx_level), .data_ready(data_ready),
        .thr_empty(thr_empty), .tx_empty(tx_empty), .fifo_en(fifo_en),
        .dma_mode(dma_mode), .trig_level(trig_level),
        .timeout_pend(timeout_pend), .overrun(overrun)
    );

    // ---------------- reference model ----------------
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit m_en = 0, m_dma = 0, m_ovr = 0, m_pend = 0, m_txe = 1, m_armed = 0;
    bit [1:0] m_trig = 0;
    int m_cnt = 0;

    function automatic int trig_of(bit [1:0] c);
        case (c)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic void model_edge();
        int  cap   = m_en ? DEPTH : 1;
        int  rsz   = rxq.size();
        int  tsz   = txq.size();
        bit  flip  = fcr_we && (fcr_wdata[0] != m_en);
        bit  frx   = fcr_we && (fcr_wdata[1] || flip);
        bit  ftx   = fcr_we && (fcr_wdata[2] || flip);
        bit  rd_ok = rd_en && rsz > 0;
        bit  pu_ok = rx_push && (rsz < cap || rd_ok);
        bit  po_ok = tx_pop && tsz > 0;
        bit  wr_ok = thr_we && (tsz < cap || po_ok);
        bit  rest  = m_en && (pu_ok || (rd_ok && rsz > 1));
        bit  expd  = m_armed && m_cnt <= 1;
        if (frx) begin
            rxq.delete(); m_ovr = 0; m_armed = 0; m_cnt = 0; m_pend = 0;
        end else begin
            if (rd_ok) void'(rxq.pop_front());
            if (pu_ok) rxq.push_back(rx_byte);
            if (rx_push && !pu_ok) m_ovr = 1;
            if (rd_en) m_pend = 0;
            else if (expd && rsz != 0) m_pend = 1;
            if (rest) begin m_armed = 1; m_cnt = 4 * int'(char_time); end
            else if (m_armed) begin
                if (expd) m_armed = 0; else m_cnt--;
            end
        end
        if (ftx) txq.delete();
        else begin
            if (po_ok) void'(txq.pop_front());
            if (wr_ok) txq.push_back(thr_wdata);
        end
        if (thr_we) m_txe = 0;
        else if (tsz == 0 && ser_idle) m_txe = 1;
        if (fcr_we) begin
            m_en = fcr_wdata[0]; m_dma = fcr_wdata[3]; m_trig = fcr_wdata[7:6];
        end
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R5 rd_data",   rd_data,  rxq.size() ? int'(rxq[0]) : 0);
        chk("R5 rx_level",  rx_level, rxq.size());
        chk("R9 data_ready", data_ready, rxq.size() != 0);
        chk("R10 tx_level", tx_level, txq.size());
        chk("R10 thr_empty", thr_empty, txq.size() == 0);
        chk("R10 tx_data",  tx_data,  txq.size() ? int'(txq[0]) : 0);
        chk("R10 tx_avail", tx_avail, txq.size() != 0);
        chk("R11 tx_empty", tx_empty, m_txe);
        chk("R1 fifo_en",   fifo_en,  m_en);
        chk("R1 dma_mode",  dma_mode, m_dma);
        chk("R2 trig_level", trig_level, trig_of(m_trig));
        chk("R7 timeout_pend", timeout_pend, m_pend);
        chk("R6 overrun",   overrun,  m_ovr);
    endtask

    // One cycle: compare current state, drive, advance model, clock edge
    task automatic step(bit fw, logic [7:0] fd, bit pu, logic [7:0] pb,
                        bit rd, bit tw, logic [7:0] td, bit tp, bit idle);
        @(negedge clk);
        compare_all();
        fcr_we = fw; fcr_wdata = fd; rx_push = pu; rx_byte = pb; rd_en = rd;
        thr_we = tw; thr_wdata = td; tx_pop = tp; ser_idle = idle;
        model_edge();
        @(posedge clk);
        #1;
    endtask

    task automatic nop(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        // Reset state (R1, R11)
        chk("R1 reset fifo_en", fifo_en, 0);
        chk("R11 reset tx_empty", tx_empty, 1);
        chk("R2 reset trig_level", trig_level, 1);

        // R2: each trigger code (enable held on after the first write)
        step(1, 8'h01, 0, 0, 0, 0, 0, 0, 0);
        for (int c = 0; c < 4; c++) begin
            step(1, {c[1:0], 6'h01}, 0, 0, 0, 0, 0, 0, 0);
            chk("R2 trig decode", trig_level, trig_of(c[1:0]));
        end
        // R1: unretained bits and dma
        step(1, 8'h3F, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 dma kept", dma_mode, 1);
        chk("R2 code 00", trig_level, 1);
        step(1, 8'h41, 0, 0, 0, 0, 0, 0, 0);

        // R7/R8: timeout exactly 4*char_time cycles after push
        char_time = 16'd3;
        step(0, 0, 1, 8'hA5, 0, 0, 0, 0, 0);
        nop(11);
        chk("R7 no early timeout", timeout_pend, 0);
        nop(1);
        chk("R7 timeout at 12", timeout_pend, 1);
        step(0, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R8 read clears timeout", timeout_pend, 0);
        chk("R5 read drains", rx_level, 0);

        // R6: 17 pushes into 16-deep queue
        for (int i = 0; i < 17; i++) step(0, 0, 1, 8'(i + 1), 0, 0, 0, 0, 0);
        chk("R6 full level", rx_level, 16);
        chk("R6 overrun set", overrun, 1);
        chk("R5 oldest first", rd_data, 1);

        // R4: receive-only flush leaves transmit side
        step(0, 0, 0, 0, 0, 1, 8'h77, 0, 0);
        step(1, 8'h43, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 rx flushed", rx_level, 0);
        chk("R4 overrun cleared", overrun, 0);
        chk("R4 tx kept", tx_level, 1);
        chk("R4 enable kept", fifo_en, 1);

        // R3: enable toggle flushes both
        step(0, 0, 1, 8'h11, 0, 0, 0, 0, 0);
        step(1, 8'h40, 0, 0, 0, 0, 0, 0, 0);
        chk("R3 rx flushed", rx_level, 0);
        chk("R3 tx flushed", tx_level, 0);

        // R5: single-register mode
        step(0, 0, 1, 8'h21, 0, 0, 0, 0, 0);
        step(0, 0, 1, 8'h22, 0, 0, 0, 0, 0);
        chk("R5 single cap", rx_level, 1);
        chk("R5 first kept", rd_data, 8'h21);
        chk("R6 single overrun", overrun, 1);

        // R10/R11: holding write, pop, idle
        step(0, 0, 0, 0, 0, 1, 8'h55, 0, 0);
        chk("R11 write clears tx_empty", tx_empty, 0);
        chk("R10 not empty", thr_empty, 0);
        step(0, 0, 0, 0, 0, 1, 8'h66, 0, 0);
        chk("R10 full drop", tx_data, 8'h55);
        step(0, 0, 0, 0, 0, 0, 0, 1, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R11 tx_empty sets", tx_empty, 1);

        // Random phase
        step(1, 8'h81, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4000; i++) begin
            bit fw = ($urandom % 100) < 2;
            logic [7:0] fd = 8'($urandom);
            if (($urandom % 4) != 0) fd[0] = 1'b1;
            char_time = 16'(1 + $urandom % 3);
            step(fw, fd, ($urandom % 100) < 35, 8'($urandom),
                 ($urandom % 100) < 20, ($urandom % 100) < 30, 8'($urandom),
                 ($urandom % 100) < 30, ($urandom % 2) == 1);
        end
        @(negedge clk);
        compare_all();
        finish_run();
    end

endmodule